// File: doc/BRIEF.md
# Tile-Major DRAM Address Generator

This block walks a two-dimensional weight matrix that is stored tile by tile and issues one physical DRAM byte address per matrix element. The matrix is cut into tiles whose height equals the DRAM interleave chunk, measured in elements, and whose width equals the bank count. Inside a tile the walk runs down each column in turn. Across the matrix the tiles themselves are visited column of tiles by column of tiles.

Each address is the latched base plus an offset packed from fixed fields. The low bits of the running within-bank element index select the channel. The next bits select the DRAM column, the local tile column selects the bank, and the remaining index bits select the DRAM row. As a result, a whole local tile column sits in one bank, and successive elements of a matrix column rotate across channels. Both per-bank column reads and row-wise bulk reads can use this single copy of the matrix without rearranging it.

A request carries the matrix size and the base address. The stream leaves through a valid/ready port together with the element coordinates. A one-cycle done pulse marks the end of a walk, and a one-cycle error pulse rejects an illegal size.

Top module: `tmag_top`

## Requirements
- R1: Within a tile, elements are issued with the local row advancing fastest, from 0 to TILE_H-1 (8), and then the local column advancing, from 0 to NUM_BANKS-1 (4).
- R2: Tiles are issued with the tile-row index advancing fastest and the tile-column index advancing slowest.
- R3: The address is base + offset, where offset = (k>>7)<<11 | lc<<9 | ((k>>1)&63)<<3 | (k&1)<<2. Here k = t*8 + lr, t = tc*(rows/8) + tr, and lr/lc/tr/tc are the local and tile coordinates. The address wraps modulo 2^32.
- R4: All elements of one local tile column carry the same bank field, bits [10:9] of the offset.
- R5: Two successive elements in the same local tile column differ by one in the channel field, bit [2] of the offset, modulo the channel count.
- R6: While out_valid is high and out_ready is low, out_addr, out_row and out_col hold their values and out_valid stays high.
- R7: In the cycle after the handshake of the last element, done is high for exactly one cycle, out_valid is low, and start_ready is high again.
- R8: A start with rows or cols equal to zero, rows not a multiple of 8, or cols not a multiple of 4 pulses err for one cycle and issues no element.
- R9: While a walk is in progress, start_ready is low and start is ignored. Neither the stream nor err changes.
- R10: No address repeats within one walk, and the walk issues exactly rows*cols elements.
- R11: out_row and out_col give the matrix row and column of the issued element.
- R12: After reset, out_valid, done and err are low and start_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a walk |
| start_ready | output | 1 | Block idle, request accepted |
| mat_rows | input | 12 | Matrix row count |
| mat_cols | input | 12 | Matrix column count |
| base_addr | input | 32 | Byte address of the matrix |
| out_valid | output | 1 | Address stream valid |
| out_ready | input | 1 | Address stream ready |
| out_addr | output | 32 | Element byte address |
| out_row | output | 12 | Element row |
| out_col | output | 12 | Element column |
| done | output | 1 | Walk finished pulse |
| err | output | 1 | Illegal size pulse |

## Verification
An accepted start raises out_valid in the following cycle, and each element is held until the cycle in which ready is sampled high. The bench therefore drives inputs and samples outputs on the falling edge, and it records an element only when valid and ready are both high at that point. done and err both come one register after their trigger: done follows the last accepted element and err follows the rejected start. The bench looks for them at the first falling edge after that rising edge and confirms at the next falling edge that they have cleared. Stall stability is compared between consecutive falling edges while ready is held low.

// File: rtl/tmag_pkg.sv
package tmag_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tmag_state_e;
endpackage

// File: rtl/tmag_dim_check.sv
module tmag_dim_check #(
  parameter int DIM_W   = 12,
  parameter int TH_LOG2 = 3,
  parameter int NB_LOG2 = 2
) (
  input  logic [DIM_W-1:0] rows,
  input  logic [DIM_W-1:0] cols,
  output logic             legal,
  output logic [DIM_W-1:0] n_trow,
  output logic [DIM_W-1:0] n_tcol
);
  localparam logic [DIM_W-1:0] ROW_MASK = DIM_W'((1 << TH_LOG2) - 1);
  localparam logic [DIM_W-1:0] COL_MASK = DIM_W'((1 << NB_LOG2) - 1);

  always_comb begin
    legal  = (rows != '0) && (cols != '0) &&
             ((rows & ROW_MASK) == '0) && ((cols & COL_MASK) == '0);
    n_trow = rows >> TH_LOG2;
    n_tcol = cols >> NB_LOG2;
  end
endmodule

// File: rtl/tmag_walker.sv
module tmag_walker
  import tmag_pkg::*;
#(
  parameter int DIM_W   = 12,
  parameter int TH_LOG2 = 3,
  parameter int NB_LOG2 = 2,
  localparam int KW     = 2 * DIM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               legal,
  input  logic [DIM_W-1:0]   n_trow,
  input  logic [DIM_W-1:0]   n_tcol,
  input  logic               out_ready,
  output logic               out_valid,
  output logic               start_ready,
  output logic               accept,
  output logic               done,
  output logic               err,
  output logic [TH_LOG2-1:0] lr,
  output logic [NB_LOG2-1:0] lc,
  output logic [DIM_W-1:0]   tr,
  output logic [DIM_W-1:0]   tc,
  output logic [KW-1:0]      tidx,
  output logic               lr_last
);
  localparam logic [TH_LOG2-1:0] LR_MAX = TH_LOG2'((1 << TH_LOG2) - 1);
  localparam logic [NB_LOG2-1:0] LC_MAX = NB_LOG2'((1 << NB_LOG2) - 1);

  tmag_state_e        state_q, state_d;
  logic [TH_LOG2-1:0] lr_q, lr_d;
  logic [NB_LOG2-1:0] lc_q, lc_d;
  logic [DIM_W-1:0]   tr_q, tr_d, tc_q, tc_d;
  logic [DIM_W-1:0]   ntr_q, ntc_q;
  logic [KW-1:0]      tidx_q, tidx_d;
  logic               done_q, done_d, err_q, err_d;
  logic               cnt_en, lc_last, tr_last, tc_last;

  always_comb begin
    lr_last = (lr_q == LR_MAX);
    lc_last = (lc_q == LC_MAX);
    tr_last = (tr_q == ntr_q - DIM_W'(1));
    tc_last = (tc_q == ntc_q - DIM_W'(1));
    accept  = (state_q == ST_IDLE) && start && legal;
    cnt_en  = accept || ((state_q == ST_RUN) && out_ready);
  end

  always_comb begin
    state_d = state_q;
    lr_d    = lr_q;
    lc_d    = lc_q;
    tr_d    = tr_q;
    tc_d    = tc_q;
    tidx_d  = tidx_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (legal) begin
            state_d = ST_RUN;
            lr_d    = '0;
            lc_d    = '0;
            tr_d    = '0;
            tc_d    = '0;
            tidx_d  = '0;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (out_ready) begin
          if (!lr_last) begin
            lr_d = lr_q + TH_LOG2'(1);
          end else begin
            lr_d = '0;
            if (!lc_last) begin
              lc_d = lc_q + NB_LOG2'(1);
            end else begin
              lc_d   = '0;
              tidx_d = tidx_q + KW'(1);
              if (!tr_last) begin
                tr_d = tr_q + DIM_W'(1);
              end else begin
                tr_d = '0;
                if (!tc_last) begin
                  tc_d = tc_q + DIM_W'(1);
                end else begin
                  tc_d    = '0;
                  state_d = ST_IDLE;
                  done_d  = 1'b1;
                end
              end
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q   <= '0;
      lc_q   <= '0;
      tr_q   <= '0;
      tc_q   <= '0;
      tidx_q <= '0;
    end else if (cnt_en) begin
      lr_q   <= lr_d;
      lc_q   <= lc_d;
      tr_q   <= tr_d;
      tc_q   <= tc_d;
      tidx_q <= tidx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ntr_q <= '0;
      ntc_q <= '0;
    end else if (accept) begin
      ntr_q <= n_trow;
      ntc_q <= n_tcol;
    end
  end

  always_comb begin
    out_valid   = (state_q == ST_RUN);
    start_ready = (state_q == ST_IDLE);
    done        = done_q;
    err         = err_q;
    lr          = lr_q;
    lc          = lc_q;
    tr          = tr_q;
    tc          = tc_q;
    tidx        = tidx_q;
  end

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && start_ready));
  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);
  assert_busy_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !start_ready);
  assert_err_after_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ready && start && !legal) |=> (err && !out_valid));
endmodule

// File: rtl/tmag_addr_map.sv
module tmag_addr_map #(
  parameter int ADDR_W   = 32,
  parameter int DIM_W    = 12,
  parameter int TH_LOG2  = 3,
  parameter int NB_LOG2  = 2,
  parameter int OFF_BITS = 2,
  parameter int CH_BITS  = 1,
  parameter int COL_BITS = 6,
  localparam int KW      = 2 * DIM_W
) (
  input  logic [ADDR_W-1:0]   base,
  input  logic [KW-1:0]       tidx,
  input  logic [TH_LOG2-1:0]  lr,
  input  logic [NB_LOG2-1:0]  lc,
  output logic [ADDR_W-1:0]   addr,
  output logic [CH_BITS-1:0]  chan,
  output logic [NB_LOG2-1:0]  bank
);
  localparam int KX       = KW + TH_LOG2;
  localparam int CH_LSB   = OFF_BITS;
  localparam int COL_LSB  = CH_LSB + CH_BITS;
  localparam int BANK_LSB = COL_LSB + COL_BITS;
  localparam int ROW_LSB  = BANK_LSB + NB_LOG2;
  localparam int LOW_K    = CH_BITS + COL_BITS;

  logic [KX-1:0]       k;
  logic [COL_BITS-1:0] colf;
  logic [KX-1:0]       rowf;
  logic [ADDR_W-1:0]   offs;

  always_comb begin
    k    = {tidx, lr};
    chan = k[CH_BITS-1:0];
    colf = k[CH_BITS +: COL_BITS];
    rowf = k >> LOW_K;
    bank = lc;
    offs = (ADDR_W'(rowf) << ROW_LSB) |
           (ADDR_W'(bank) << BANK_LSB) |
           (ADDR_W'(colf) << COL_LSB) |
           (ADDR_W'(chan) << CH_LSB);
    addr = base + offs;
  end
endmodule

// File: rtl/tmag_top.sv
module tmag_top #(
  parameter int ADDR_W      = 32,
  parameter int DIM_W       = 12,
  parameter int TH_LOG2     = 3,
  parameter int NB_LOG2     = 2,
  parameter int OFF_BITS    = 2,
  parameter int CH_BITS     = 1,
  parameter int COL_BITS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              start_ready,
  input  logic [DIM_W-1:0]  mat_rows,
  input  logic [DIM_W-1:0]  mat_cols,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DIM_W-1:0]  out_row,
  output logic [DIM_W-1:0]  out_col,
  output logic              done,
  output logic              err
);
  localparam int KW = 2 * DIM_W;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sn;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_rsync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe[s] <= 1'b0;
        else if (s == 0) rst_pipe[s] <= 1'b1;
        else rst_pipe[s] <= rst_pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign rst_sn = rst_pipe[SYNC_STAGES-1];

  logic               legal, accept, lr_last;
  logic [DIM_W-1:0]   n_trow, n_tcol, tr, tc;
  logic [TH_LOG2-1:0] lr;
  logic [NB_LOG2-1:0] lc;
  logic [KW-1:0]      tidx;
  logic [ADDR_W-1:0]  base_q;
  logic [CH_BITS-1:0] chan;
  logic [NB_LOG2-1:0] bank;

  tmag_dim_check #(.DIM_W(DIM_W), .TH_LOG2(TH_LOG2), .NB_LOG2(NB_LOG2)) i_dim (
    .rows(mat_rows), .cols(mat_cols), .legal(legal),
    .n_trow(n_trow), .n_tcol(n_tcol)
  );

  tmag_walker #(.DIM_W(DIM_W), .TH_LOG2(TH_LOG2), .NB_LOG2(NB_LOG2)) i_walk (
    .clk(clk), .rst_n(rst_sn), .start(start), .legal(legal),
    .n_trow(n_trow), .n_tcol(n_tcol), .out_ready(out_ready),
    .out_valid(out_valid), .start_ready(start_ready), .accept(accept),
    .done(done), .err(err), .lr(lr), .lc(lc), .tr(tr), .tc(tc),
    .tidx(tidx), .lr_last(lr_last)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) base_q <= '0;
    else if (accept) base_q <= base_addr;
  end

  tmag_addr_map #(
    .ADDR_W(ADDR_W), .DIM_W(DIM_W), .TH_LOG2(TH_LOG2), .NB_LOG2(NB_LOG2),
    .OFF_BITS(OFF_BITS), .CH_BITS(CH_BITS), .COL_BITS(COL_BITS)
  ) i_map (
    .base(base_q), .tidx(tidx), .lr(lr), .lc(lc),
    .addr(out_addr), .chan(chan), .bank(bank)
  );

  always_comb begin
    out_row = DIM_W'({tr, lr});
    out_col = DIM_W'({tc, lc});
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
                                   $stable(out_row) && $stable(out_col)));
  assert_bank_column_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && out_ready && !lr_last) |=> (bank == $past(bank)));
  assert_chan_step_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && out_ready && !lr_last) |=> (chan == $past(chan) + CH_BITS'(1)));
  assert_row_step_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && out_ready && !lr_last) |=>
      (out_row == $past(out_row) + DIM_W'(1) && out_col == $past(out_col)));
endmodule

// File: tb/test_tmag_top.sv
module test_tmag_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        start_ready;
  logic [11:0] mat_rows, mat_cols;
  logic [31:0] base_addr;
  logic        out_valid, out_ready;
  logic [31:0] out_addr;
  logic [11:0] out_row, out_col;
  logic        done, err;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  tmag_top i_tmag_top (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ready(start_ready),
    .mat_rows(mat_rows), .mat_cols(mat_cols), .base_addr(base_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_row(out_row), .out_col(out_col), .done(done), .err(err)
  );

  // rows, cols, base, ready mode
  localparam logic [31:0] VEC [5][4] = '{
    '{32'd8,  32'd4,  32'h0000_0000, 32'd0},
    '{32'd16, 32'd8,  32'h0000_1000, 32'd1},
    '{32'd24, 32'd4,  32'h0040_0000, 32'd2},
    '{32'd8,  32'd12, 32'hFFFF_F000, 32'd0},
    '{32'd32, 32'd8,  32'h0123_4000, 32'd1}
  };

  logic [31:0] ea [256];
  int          er [256];
  int          ec [256];
  logic [31:0] seen [256];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_addr(input int rows, input int r, input int c,
                                           input logic [31:0] base);
    int tr = r / 8, lr = r % 8, tc = c / 4, lc = c % 4;
    longint t = longint'(tc) * (rows / 8) + tr;
    longint k = t * 8 + lr;
    longint off = ((k >> 7) << 11) | (longint'(lc) << 9) |
                  (((k >> 1) & 63) << 3) | ((k & 1) << 2);
    return base + 32'(off);
  endfunction

  function automatic bit ready_of(input int mode, input int cyc);
    if (mode == 1) return (cyc % 2) == 0;
    if (mode == 2) return (cyc % 3) != 2;
    return 1'b1;
  endfunction

  task automatic run_case(input int rows, input int cols, input logic [31:0] base,
                          input int mode, input bit inject);
    int n = rows * cols;
    int idx = 0, got = 0, cyc = 0;
    bit stalled = 0, dup = 0;
    logic [31:0] h_addr;
    int h_row, h_col;
    // expected walk: tile columns, tile rows, local columns, local rows (R1, R2)
    for (int tc = 0; tc < cols / 4; tc++)
      for (int tr = 0; tr < rows / 8; tr++)
        for (int lc = 0; lc < 4; lc++)
          for (int lr = 0; lr < 8; lr++) begin
            er[idx] = tr * 8 + lr;
            ec[idx] = tc * 4 + lc;
            ea[idx] = ref_addr(rows, er[idx], ec[idx], base);
            idx++;
          end
    @(negedge clk);
    mat_rows = 12'(rows); mat_cols = 12'(cols); base_addr = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    base_addr = 32'hDEAD_BEE0;
    while (got < n && cyc < 5000) begin
      out_ready = ready_of(mode, cyc);
      if (inject && cyc == 2) begin
        chk(start_ready == 1'b0, "R9 start_ready busy", start_ready, 0);
        start = 1'b1; mat_rows = 12'd12;
      end
      if (stalled)
        chk(out_valid && out_addr == h_addr && int'(out_row) == h_row && int'(out_col) == h_col,
            "R6 hold", out_addr, h_addr);
      stalled = 0;
      if (out_valid) begin
        if (out_ready) begin
          chk(out_addr == ea[got], "R1/R2/R3 addr", out_addr, ea[got]);
          chk(int'(out_row) == er[got] && int'(out_col) == ec[got], "R11 coords",
              {out_row, out_col}, {12'(er[got]), 12'(ec[got])});
          for (int j = 0; j < got; j++) if (seen[j] == out_addr) dup = 1;
          seen[got] = out_addr;
          got++;
        end else begin
          stalled = 1; h_addr = out_addr; h_row = int'(out_row); h_col = int'(out_col);
        end
      end
      @(negedge clk);
      start = 1'b0;
      mat_rows = 12'(rows);
      if (inject) chk(err == 1'b0, "R9 no err while busy", err, 0);
      cyc++;
    end
    out_ready = 1'b0;
    chk(got == n, "R10 element count", got, n);
    chk(dup == 0, "R10 unique addresses", dup, 0);
    chk(done == 1'b1 && out_valid == 1'b0, "R7 done pulse", {done, out_valid}, 2'b10);
    @(negedge clk);
    chk(done == 1'b0 && start_ready == 1'b1, "R7 done one cycle", {done, start_ready}, 2'b01);
  endtask

  task automatic bad_dims(input int rows, input int cols);
    @(negedge clk);
    mat_rows = 12'(rows); mat_cols = 12'(cols); start = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1 && out_valid == 1'b0, "R8 err pulse", {err, out_valid}, 2'b10);
    @(negedge clk);
    chk(err == 1'b0 && out_valid == 1'b0 && start_ready == 1'b1, "R8 err one cycle, no stream",
        {err, out_valid, start_ready}, 3'b001);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b0;
    mat_rows = '0; mat_cols = '0; base_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 0 && done == 0 && err == 0 && start_ready == 1, "R12 reset state",
        {out_valid, done, err, start_ready}, 4'b0001);
    for (int i = 0; i < 5; i++)
      run_case(int'(VEC[i][0]), int'(VEC[i][1]), VEC[i][2], int'(VEC[i][3]), 1'b0);
    bad_dims(12, 4);
    bad_dims(8, 6);
    bad_dims(0, 4);
    bad_dims(16, 0);
    run_case(16, 4, 32'h0000_8000, 2, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule